// File: doc/BRIEF.md
# Clock Lock and Jitter Measurement Counter

This block measures a forwarded clock against a local reference. Two equal-width counters work as a pair. A start pulse clears both counters and arms them together. The reference counter then runs until its top bit sets. That event closes the observation window for both counters. When both clock domains report that they have halted, the block raises `done`. It also compares the two final counts to decide whether the measured clock runs at the reference frequency.

A select input picks the measured clock: the forwarded source clock or the regenerated receiver clock. In frequency mode, the test counter advances once per cycle of the chosen clock. In jitter mode, the reference clock samples the chosen clock. The test counter then counts only low-then-high sample pairs. An outside controller steps the relative phase between runs and collects one count per phase setting, which gives a histogram of edge positions. Mode and clock select must be held steady from the start pulse until `done`.

The counts appear on plain status outputs. They change only when a run finishes, so they are not a stream and have no valid/ready handshake or back-pressure. All control and status pins are level or pulse signals in the reference domain.

Top module: `clk_meas_backend`

## Requirements
- R1: A one-cycle `start` pulse, taken while the block is idle or done, drops `done` and `match` on the next reference edge. It also clears both counters to zero.
- R2: The reference counter stops when its most significant bit sets, so its final value is 2^(CNT_W-1). The test counter stops with it.
- R3: In frequency mode (`mode`=0), the test counter counts cycles of the selected clock during the window. `exp_sel`=0 selects `src_clk` and `exp_sel`=1 selects `rx_clk`.
- R4: At the end of a run, `match` is 1 exactly when the two final counts differ by at most MATCH_TOL. `match` is never 1 while `done` is 0.
- R5: `done` rises only after the test domain has confirmed that its counter is halted. It then holds until the next accepted start.
- R6: In jitter mode (`mode`=1), the test counter increments once for each reference-clock sample of the selected clock that reads 1 when the previous sample read 0. A selected clock at the reference frequency therefore yields no counts.
- R7: `tst_count` and `ref_count` update only when `done` rises. While a run is in progress they keep the previous run's values.
- R8: A `start` pulse that arrives while a measurement is in progress is ignored. The run in progress is not restarted.
- R9: After reset, `done`, `match`, `tst_count` and `ref_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also the sampling clock in jitter mode |
| src_clk | input | 1 | Forwarded source clock |
| rx_clk | input | 1 | Regenerated receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_sel | input | 1 | Measured clock select: 0 source, 1 receiver |
| mode | input | 1 | 0 frequency check, 1 jitter sampling |
| start | input | 1 | One-cycle start pulse, reference domain |
| done | output | 1 | Run finished and both domains halted |
| match | output | 1 | Counts agree within tolerance; valid while done |
| tst_count | output | CNT_W | Final test count of the last finished run |
| ref_count | output | CNT_W | Final reference count of the last finished run |

## Verification
The bench builds the block with CNT_W=8 and MATCH_TOL=2. This shrinks the observation window to 128 reference cycles, so several complete runs fit in a short test. The same-frequency case, an offset-frequency case (about 160 counts) and both jitter patterns (about 64 counts, and exactly 0) can each be reached and checked against hand-computed counts. The small window also makes a start pulse in the middle of a run easy to place, and lets the bench time the remaining run to show that no restart occurred.

// File: rtl/clkmeas_pkg.sv
package clkmeas_pkg;
  typedef enum logic {
    MODE_FREQ = 1'b0,
    MODE_JIT  = 1'b1
  } meas_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLR   = 3'd1,
    ST_RUN   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_DONE  = 3'd4
  } ref_st_e;
endpackage

// File: rtl/cm_sync2.sv
module cm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cm_test_ctr.sv
module cm_test_ctr #(
  parameter int CNT_W = 30
) (
  input  logic             tc_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             jit_mode,
  input  logic             sel_clk,
  input  logic             clr_tgl,
  input  logic             run,
  output logic             ack_tgl,
  output logic             run_echo,
  output logic [CNT_W-1:0] tcnt
);
  logic clr_s, clr_q, clr_evt;
  logic run_s;
  logic smp, smp_q, hit;

  // start/clear handoff and window gate, test domain
  cm_sync2 u_clr_sync (.clk(tc_clk), .rst_n(rst_n), .d(clr_tgl), .q(clr_s));
  cm_sync2 u_run_sync (.clk(tc_clk), .rst_n(rst_n), .d(run),     .q(run_s));

  // selected clock sampled on the reference clock (jitter mode)
  cm_sync2 u_smp_sync (.clk(ref_clk), .rst_n(rst_n), .d(sel_clk), .q(smp));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= smp;
  end

  assign hit     = smp & ~smp_q;
  assign clr_evt = clr_s ^ clr_q;

  always_ff @(posedge tc_clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q   <= 1'b0;
      ack_tgl <= 1'b0;
      tcnt    <= '0;
    end else begin
      clr_q <= clr_s;
      if (clr_evt) begin
        tcnt    <= '0;
        ack_tgl <= ~ack_tgl;
      end else if (run_s && (!jit_mode || hit)) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign run_echo = run_s;

  AST_CLEAR_ACKED: assert property (@(posedge tc_clk) disable iff (!rst_n)
    clr_evt |=> (tcnt == '0 && ack_tgl != $past(ack_tgl))); // R1
endmodule

// File: rtl/cm_ref_ctrl.sv
module cm_ref_ctrl
  import clkmeas_pkg::*;
#(
  parameter int CNT_W     = 30,
  parameter int MATCH_TOL = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] tcnt_in,
  input  logic             ack_tgl,
  input  logic             run_echo,
  output logic             clr_tgl,
  output logic             run,
  output logic             done,
  output logic             match,
  output logic [CNT_W-1:0] snap_tst,
  output logic [CNT_W-1:0] snap_ref
);
  localparam logic [CNT_W-1:0] TERM     = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] TERM_M1  = TERM - 1'b1;
  localparam logic [CNT_W-1:0] TOL_W    = CNT_W'(MATCH_TOL);

  ref_st_e          st;
  logic [CNT_W-1:0] rcnt;
  logic             ack_s, ack_q, ack_evt;
  logic             echo_s, seen_hi;
  logic [CNT_W-1:0] diff;
  logic             idle_like;

  cm_sync2 u_ack_sync  (.clk(ref_clk), .rst_n(rst_n), .d(ack_tgl),  .q(ack_s));
  cm_sync2 u_echo_sync (.clk(ref_clk), .rst_n(rst_n), .d(run_echo), .q(echo_s));

  assign ack_evt   = ack_s ^ ack_q;
  assign idle_like = (st == ST_IDLE) || (st == ST_DONE);
  assign diff      = (tcnt_in >= rcnt) ? (tcnt_in - rcnt) : (rcnt - tcnt_in);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rcnt     <= '0;
      ack_q    <= 1'b0;
      clr_tgl  <= 1'b0;
      run      <= 1'b0;
      seen_hi  <= 1'b0;
      done     <= 1'b0;
      match    <= 1'b0;
      snap_tst <= '0;
      snap_ref <= '0;
    end else begin
      ack_q <= ack_s;
      unique case (st)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            clr_tgl <= ~clr_tgl;
            rcnt    <= '0;
            done    <= 1'b0;
            match   <= 1'b0;
            seen_hi <= 1'b0;
            st      <= ST_CLR;
          end
        end
        ST_CLR: begin
          if (ack_evt) begin
            run <= 1'b1;
            st  <= ST_RUN;
          end
        end
        ST_RUN: begin
          rcnt <= rcnt + 1'b1;
          if (echo_s) seen_hi <= 1'b1;
          if (rcnt == TERM_M1) begin
            run <= 1'b0;
            st  <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (echo_s) seen_hi <= 1'b1;
          if ((seen_hi || echo_s) && !echo_s) begin
            done     <= 1'b1;
            match    <= (diff <= TOL_W);
            snap_tst <= tcnt_in;
            snap_ref <= rcnt;
            st       <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_START_ACCEPT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (start && idle_like) |=> (!done && !match && rcnt == '0)); // R1
  AST_REF_TERMINAL: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (st == ST_DRAIN) |-> (rcnt == TERM && !run)); // R2
  AST_MATCH_ONLY_DONE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    match |-> done); // R4
  AST_DONE_HALTED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(done) |-> !echo_s); // R5
  AST_FROZEN_TEST: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(tcnt_in)); // R5
  AST_BUSY_IGNORE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (start && st == ST_RUN) |=> (st == ST_RUN || st == ST_DRAIN)); // R8
  AST_SNAP_HOLD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$rose(done) |-> ($stable(snap_tst) && $stable(snap_ref))); // R7
endmodule

// File: rtl/clk_meas_backend.sv
module clk_meas_backend
  import clkmeas_pkg::*;
#(
  parameter int CNT_W     = 30,
  parameter int MATCH_TOL = 2
) (
  input  logic             ref_clk,
  input  logic             src_clk,
  input  logic             rx_clk,
  input  logic             rst_n,
  input  logic             exp_sel,
  input  logic             mode,
  input  logic             start,
  output logic             done,
  output logic             match,
  output logic [CNT_W-1:0] tst_count,
  output logic [CNT_W-1:0] ref_count
);
  meas_mode_e       mode_e;
  logic             sel_clk, tc_clk, jit;
  logic             clr_tgl, ack_tgl, run, run_echo;
  logic [CNT_W-1:0] tcnt;

  assign mode_e  = meas_mode_e'(mode);
  assign jit     = (mode_e == MODE_JIT);
  assign sel_clk = exp_sel ? rx_clk : src_clk;
  assign tc_clk  = jit ? ref_clk : sel_clk;

  cm_test_ctr #(.CNT_W(CNT_W)) u_test (
    .tc_clk   (tc_clk),
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .jit_mode (jit),
    .sel_clk  (sel_clk),
    .clr_tgl  (clr_tgl),
    .run      (run),
    .ack_tgl  (ack_tgl),
    .run_echo (run_echo),
    .tcnt     (tcnt)
  );

  cm_ref_ctrl #(.CNT_W(CNT_W), .MATCH_TOL(MATCH_TOL)) u_ref (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .start    (start),
    .tcnt_in  (tcnt),
    .ack_tgl  (ack_tgl),
    .run_echo (run_echo),
    .clr_tgl  (clr_tgl),
    .run      (run),
    .done     (done),
    .match    (match),
    .snap_tst (tst_count),
    .snap_ref (ref_count)
  );
endmodule

// File: tb/tb_clk_meas_backend.sv
`timescale 1ns/1ps
module tb_clk_meas_backend;
  localparam int W    = 8;
  localparam int TOL  = 2;
  localparam int TERM = 1 << (W-1);

  logic ref_clk = 1'b0, src_clk = 1'b0, rx_clk = 1'b0;
  logic rst_n = 1'b0, exp_sel = 1'b0, mode = 1'b0, start = 1'b0;
  logic done, match;
  logic [W-1:0] tst_count, ref_count;
  int src_half = 5;
  int rx_half  = 4;
  int n_chk = 0, n_fail = 0;

  clk_meas_backend #(.CNT_W(W), .MATCH_TOL(TOL)) dut (
    .ref_clk(ref_clk), .src_clk(src_clk), .rx_clk(rx_clk), .rst_n(rst_n),
    .exp_sel(exp_sel), .mode(mode), .start(start), .done(done), .match(match),
    .tst_count(tst_count), .ref_count(ref_count)
  );

  always #5 ref_clk = ~ref_clk;
  initial begin #2; forever #(src_half) src_clk = ~src_clk; end
  initial begin #1; forever #(rx_half)  rx_clk  = ~rx_clk;  end

  task automatic chk(input string req, input bit ok, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic pulse_start();
    @(negedge ref_clk); start = 1'b1;
    @(negedge ref_clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req, output int cycles);
    cycles = 0;
    while (!done && cycles < 3000) begin
      @(negedge ref_clk); cycles++;
    end
    chk(req, done == 1'b1, int'(done), 1);
  endtask

  task automatic t_reset();
    chk("R9 done", done == 1'b0, int'(done), 0);
    chk("R9 match", match == 1'b0, int'(match), 0);
    chk("R9 tst_count", tst_count == '0, int'(tst_count), 0);
    chk("R9 ref_count", ref_count == '0, int'(ref_count), 0);
  endtask

  task automatic t_freq_lock();
    int cyc;
    mode = 1'b0; exp_sel = 1'b0; src_half = 5;
    pulse_start();
    wait_done("R5 done after lock run", cyc);
    chk("R2 ref terminal", ref_count == W'(TERM), int'(ref_count), TERM);
    chk("R3 src count", (int'(tst_count) >= TERM-TOL) && (int'(tst_count) <= TERM+TOL),
        int'(tst_count), TERM);
    chk("R4 match same freq", match == 1'b1, int'(match), 1);
  endtask

  task automatic t_freq_offset();
    int cyc;
    mode = 1'b0; exp_sel = 1'b1; rx_half = 4;
    pulse_start();
    wait_done("R5 done after offset run", cyc);
    chk("R3 rx count", (int'(tst_count) >= 155) && (int'(tst_count) <= 165),
        int'(tst_count), 160);
    chk("R2 ref terminal offset", ref_count == W'(TERM), int'(ref_count), TERM);
    chk("R4 no match offset", match == 1'b0, int'(match), 0);
  endtask

  task automatic t_frozen_read();
    int cyc;
    logic [W-1:0] prev_t;
    prev_t = tst_count;
    mode = 1'b0; exp_sel = 1'b0; src_half = 5;
    pulse_start();
    chk("R1 done dropped", done == 1'b0, int'(done), 0);
    chk("R1 match dropped", match == 1'b0, int'(match), 0);
    repeat (40) @(negedge ref_clk);
    chk("R7 held count mid-run", tst_count == prev_t, int'(tst_count), int'(prev_t));
    wait_done("R5 done after frozen run", cyc);
    chk("R7 updated at done", (int'(tst_count) >= TERM-TOL) && (int'(tst_count) <= TERM+TOL),
        int'(tst_count), TERM);
  endtask

  task automatic t_busy_start();
    int cyc;
    mode = 1'b0; exp_sel = 1'b0;
    pulse_start();
    repeat (40) @(negedge ref_clk);
    pulse_start();
    wait_done("R8 done reached", cyc);
    chk("R8 no restart", cyc < TERM - 20, cyc, TERM - 40);
    chk("R8 ref terminal", ref_count == W'(TERM), int'(ref_count), TERM);
  endtask

  task automatic t_jitter();
    int cyc;
    mode = 1'b1; exp_sel = 1'b0; src_half = 10;
    repeat (4) @(negedge ref_clk);
    pulse_start();
    wait_done("R6 done half-rate", cyc);
    chk("R6 half-rate transitions", (int'(tst_count) >= TERM/2-2) && (int'(tst_count) <= TERM/2+2),
        int'(tst_count), TERM/2);
    chk("R4 jitter no match", match == 1'b0, int'(match), 0);
    src_half = 5;
    repeat (4) @(negedge ref_clk);
    pulse_start();
    wait_done("R6 done same-rate", cyc);
    chk("R6 same-rate no transitions", tst_count == '0, int'(tst_count), 0);
    mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
    @(negedge ref_clk);
    t_reset();
    t_freq_lock();
    t_freq_offset();
    t_frozen_read();
    t_busy_start();
    t_jitter();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule